// File: doc/BRIEF.md
# DS3 Transmit Alarm Pattern Inserter

This block sits in the serial transmit path of a DS3 line interface. It counts bit times across the 4760-bit M-frame and decides the value of every transmitted bit. It generates the framing bits (F and M) and the parity bits (P) itself. It then fills the remaining overhead and payload according to one of four transmit conditions: ordinary traffic, yellow alarm, alarm indication signal (AIS), or idle code. One line bit is consumed and one is produced on every bit clock.

An M-frame is built from seven subframes. Each subframe holds eight 85-bit blocks, and each block is one overhead bit followed by 84 payload bits. Within a subframe, the overhead bits run in this order: a lead bit, F1, C1, F2, C2, F3, C3, F4. The lead bit is an X bit in subframes 1 and 2, a P bit in subframes 3 and 4, and an M bit in subframes 5 to 7. The caller supplies the payload stream, the C-bit source stream, the framing mode and a 2-bit alarm request. The caller receives the line bit and a strobe that marks overhead bit times.

The alarm request is sampled only on the final bit of an M-frame. Every frame is therefore sent entirely under one condition.

Top module: `ds3_alarm_inserter`

## Requirements
- R1: `tx_oh` is 1 exactly in the cycles whose `tx_bit` is an overhead bit. That is the first bit of each 85-bit block. Each output appears one clock after the input bit time is consumed.
- R2: The F bits in every subframe are sent as F1=1, F2=0, F3=0, F4=1, whatever the alarm condition.
- R3: The M bits in subframes 5, 6 and 7 are sent as 0, 1, 0, whatever the alarm condition.
- R4: The alarm request is encoded as 00 normal, 01 yellow, 11 AIS and 10 idle. Both X bits are 0 under yellow. They are 1 under normal, AIS and idle.
- R5: Under AIS, every C-bit is 0 in both framing modes. The payload is 1,0,1,0,..., starting again with 1 on the first payload bit after each overhead bit.
- R6: Under idle, the payload is 1,1,0,0,..., starting again with 1,1 on the first payload bit after each overhead bit.
- R7: Under idle, when `cbp_mode`=0 (M13), all C-bits are 0. When `cbp_mode`=1 (C-bit parity), the three C-bits of subframe 3 are 0 and all other C-bits are taken from `cbit_in`.
- R8: Under normal and yellow, each payload bit equals `pay_in` and each C-bit equals `cbit_in` for that bit time.
- R9: Both P bits of a frame equal the XOR of all payload bits sent in the previous frame, after substitution. In the first frame after reset they are 0.
- R10: `alarm_sel` is sampled only during the last bit time of a frame, and it governs the next whole frame. A change at any other time has no effect. The first frame after reset is normal.
- R11: A synchronous low `rst_n` forces `tx_bit` and `tx_oh` to 0 on the next edge. After release, framing restarts at the first X bit of subframe 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pay_in | input | 1 | Payload data for the current bit time |
| cbit_in | input | 1 | C-bit source data for the current bit time |
| cbp_mode | input | 1 | Framing mode: 1 = C-bit parity, 0 = M13 |
| alarm_sel | input | 2 | Requested condition: 00 normal, 01 yellow, 11 AIS, 10 idle |
| tx_bit | output | 1 | Registered line bit |
| tx_oh | output | 1 | Registered overhead bit-time strobe |

## Verification
The properties assume that `rst_n` is held low from time zero until at least one edge has passed. They also assume that the framing counters alone define which bit time is overhead, so no input can move the frame position. The stimulus keeps to these conditions. It asserts reset before the first edge. It changes `pay_in`, `cbit_in`, `cbp_mode` and `alarm_sel` only on falling edges. It deliberately moves `alarm_sel` in the middle of frames, so the hold rule on the latched condition is exercised against requests that are not aligned to frame boundaries.

// File: rtl/ds3ai_pkg.sv
`timescale 1ns / 1ps
// Package: ds3ai_pkg
// Shared frame geometry defaults and encodings for the DS3 alarm inserter.
// Assumes the seven-subframe, eight-block structure of a DS3 M-frame.
package ds3ai_pkg;

    localparam int SUBFRAMES_DEF  = 7;
    localparam int BLOCKS_DEF     = 8;
    localparam int BLOCK_BITS_DEF = 85;

    // Transmit condition; encoding is fixed by the control interface
    typedef enum logic [1:0] {
        ALM_NORMAL = 2'b00,
        ALM_YELLOW = 2'b01,
        ALM_IDLE   = 2'b10,
        ALM_AIS    = 2'b11
    } alarm_e;

    // Overhead slot by block index inside a subframe
    typedef enum logic [2:0] {
        SLOT_LEAD = 3'd0,
        SLOT_F1   = 3'd1,
        SLOT_C1   = 3'd2,
        SLOT_F2   = 3'd3,
        SLOT_C2   = 3'd4,
        SLOT_F3   = 3'd5,
        SLOT_C3   = 3'd6,
        SLOT_F4   = 3'd7
    } slot_e;

    // Zero-based subframe whose C-bits are forced during idle in C-bit parity
    localparam int IDLE_FORCE_SF = 2;
    // First zero-based subframe carrying P, and first carrying M
    localparam int FIRST_P_SF    = 2;
    localparam int FIRST_M_SF    = 4;
    // M-bit values for the three M subframes, index 0 = first M subframe
    localparam logic [2:0] M_PATTERN = 3'b010;

endpackage

// File: rtl/ds3ai_position.sv
`timescale 1ns / 1ps
// Module: ds3ai_position
// Tracks the current bit time inside the M-frame as subframe, block and
// bit-in-block counters. Flags overhead bit times and the last bit of the frame.
// Assumes one bit time per clock and restarts at subframe 0, block 0, bit 0.
module ds3ai_position #(
    parameter int SUBFRAMES  = ds3ai_pkg::SUBFRAMES_DEF,
    parameter int BLOCKS     = ds3ai_pkg::BLOCKS_DEF,
    parameter int BLOCK_BITS = ds3ai_pkg::BLOCK_BITS_DEF,
    localparam int SF_W      = $clog2(SUBFRAMES),
    localparam int BLK_W     = $clog2(BLOCKS),
    localparam int BIT_W     = $clog2(BLOCK_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SF_W-1:0]  sf_idx,
    output logic [BLK_W-1:0] blk_idx,
    output logic             oh_slot,
    output logic             frame_last
);

    localparam logic [SF_W-1:0]  SF_LAST  = SF_W'(SUBFRAMES - 1);
    localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLOCKS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BLOCK_BITS - 1);

    logic [SF_W-1:0]  sf_q;
    logic [BLK_W-1:0] blk_q;
    logic [BIT_W-1:0] bit_q;
    logic             blk_end;
    logic             sf_end;

    // Decode the block and subframe wrap points
    always_comb begin
        blk_end = (bit_q == BIT_LAST);
        sf_end  = blk_end && (blk_q == BLK_LAST);
    end

    // Bit-in-block counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (blk_end) begin
            bit_q <= '0;
        end else begin
            bit_q <= bit_q + 1'b1;
        end
    end

    // Block-in-subframe counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= '0;
        end else if (sf_end) begin
            blk_q <= '0;
        end else if (blk_end) begin
            blk_q <= blk_q + 1'b1;
        end
    end

    // Subframe-in-frame counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sf_q <= '0;
        end else if (sf_end) begin
            sf_q <= (sf_q == SF_LAST) ? '0 : sf_q + 1'b1;
        end
    end

    // Export position flags
    always_comb begin
        sf_idx     = sf_q;
        blk_idx    = blk_q;
        oh_slot    = (bit_q == '0);
        frame_last = sf_end && (sf_q == SF_LAST);
    end

endmodule

// File: rtl/ds3ai_overhead.sv
`timescale 1ns / 1ps
// Module: ds3ai_overhead
// Chooses the overhead bit value for the current slot from the frame
// position, the latched alarm condition, the framing mode, the C-bit source
// and the stored parity. Purely combinational.
// Assumes the DS3 slot order of eight blocks per subframe.
module ds3ai_overhead
    import ds3ai_pkg::*;
#(
    parameter int SUBFRAMES = ds3ai_pkg::SUBFRAMES_DEF,
    parameter int BLOCKS    = ds3ai_pkg::BLOCKS_DEF,
    localparam int SF_W     = $clog2(SUBFRAMES),
    localparam int BLK_W    = $clog2(BLOCKS),
    localparam int SF_SPAN  = 1 << SF_W
) (
    input  logic [SF_W-1:0]  sf_idx,
    input  logic [BLK_W-1:0] blk_idx,
    input  alarm_e           alarm,
    input  logic             cbp_mode,
    input  logic             cbit_in,
    input  logic             par_bit,
    output logic             ovh_bit
);

    logic [SF_SPAN-1:0] idle_keep;
    logic               x_val;
    logic               m_val;
    logic               lead_val;
    logic               c_val;
    logic [1:0]         m_sel;

    // Per-subframe mask: which subframes keep source C-bits during idle
    for (genvar s = 0; s < SF_SPAN; s++) begin : g_idle_keep
        assign idle_keep[s] = (s != IDLE_FORCE_SF);
    end

    // X bits are cleared only under yellow
    always_comb begin
        x_val = (alarm != ALM_YELLOW);
    end

    // M-bit value for the current subframe
    always_comb begin
        m_sel = 2'(sf_idx - SF_W'(FIRST_M_SF));
        m_val = (m_sel < 2'd3) ? M_PATTERN[m_sel] : 1'b0;
    end

    // Lead bit: X, then P, then M according to subframe
    always_comb begin
        if (sf_idx < SF_W'(FIRST_P_SF)) begin
            lead_val = x_val;
        end else if (sf_idx < SF_W'(FIRST_M_SF)) begin
            lead_val = par_bit;
        end else begin
            lead_val = m_val;
        end
    end

    // C-bit substitution per alarm condition and framing mode
    always_comb begin
        unique case (alarm)
            ALM_AIS:  c_val = 1'b0;
            ALM_IDLE: c_val = cbp_mode ? (cbit_in & idle_keep[sf_idx]) : 1'b0;
            default:  c_val = cbit_in;
        endcase
    end

    // Slot multiplexer
    always_comb begin
        unique case (slot_e'(blk_idx))
            SLOT_LEAD: ovh_bit = lead_val;
            SLOT_F1:   ovh_bit = 1'b1;
            SLOT_F2:   ovh_bit = 1'b0;
            SLOT_F3:   ovh_bit = 1'b0;
            SLOT_F4:   ovh_bit = 1'b1;
            default:   ovh_bit = c_val;
        endcase
    end

endmodule

// File: rtl/ds3ai_filler.sv
`timescale 1ns / 1ps
// Module: ds3ai_filler
// Produces the payload bit: the caller's data, or the AIS or idle filler.
// A phase counter is cleared on every overhead bit time, so each filler
// pattern starts again after overhead.
// Assumes that oh_slot marks the bit time just before the first payload bit.
module ds3ai_filler
    import ds3ai_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   oh_slot,
    input  alarm_e alarm,
    input  logic   pay_in,
    output logic   pay_bit
);

    logic [1:0] phase_q;

    // Filler phase, cleared on overhead and advanced on each payload bit
    always_ff @(posedge clk) begin
        if (!rst_n || oh_slot) begin
            phase_q <= 2'd0;
        end else begin
            phase_q <= phase_q + 2'd1;
        end
    end

    // Select caller data or filler pattern
    always_comb begin
        unique case (alarm)
            ALM_AIS:  pay_bit = ~phase_q[0];
            ALM_IDLE: pay_bit = ~phase_q[1];
            default:  pay_bit = pay_in;
        endcase
    end

endmodule

// File: rtl/ds3ai_parity.sv
`timescale 1ns / 1ps
// Module: ds3ai_parity
// Accumulates the XOR of every payload bit sent in a frame. The result is
// stored at the frame's last bit and offered as the P value for the next frame.
// Assumes that the last bit of a frame is a payload bit.
module ds3ai_parity (
    input  logic clk,
    input  logic rst_n,
    input  logic oh_slot,
    input  logic frame_last,
    input  logic line_bit,
    output logic par_bit
);

    logic acc_q;
    logic par_q;
    logic acc_next;

    // Fold the current payload bit into the running parity
    always_comb begin
        acc_next = acc_q ^ (line_bit & ~oh_slot);
    end

    // Running parity, cleared at each frame end
    always_ff @(posedge clk) begin
        if (!rst_n || frame_last) begin
            acc_q <= 1'b0;
        end else begin
            acc_q <= acc_next;
        end
    end

    // Stored parity for the following frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= 1'b0;
        end else if (frame_last) begin
            par_q <= acc_next;
        end
    end

    assign par_bit = par_q;

endmodule

// File: rtl/ds3_alarm_inserter.sv
`timescale 1ns / 1ps
// Module: ds3_alarm_inserter
// Top of the DS3 transmit alarm inserter. Latches the alarm request at frame
// boundaries, merges the overhead and payload sources, and registers the
// line bit together with its overhead strobe.
// Assumes one bit time per clock and a request encoding from ds3ai_pkg.
module ds3_alarm_inserter
    import ds3ai_pkg::*;
#(
    parameter int SUBFRAMES  = ds3ai_pkg::SUBFRAMES_DEF,
    parameter int BLOCKS     = ds3ai_pkg::BLOCKS_DEF,
    parameter int BLOCK_BITS = ds3ai_pkg::BLOCK_BITS_DEF,
    localparam int SF_W      = $clog2(SUBFRAMES),
    localparam int BLK_W     = $clog2(BLOCKS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pay_in,
    input  logic       cbit_in,
    input  logic       cbp_mode,
    input  logic [1:0] alarm_sel,
    output logic       tx_bit,
    output logic       tx_oh
);

    logic [SF_W-1:0]  sf_idx;
    logic [BLK_W-1:0] blk_idx;
    logic             oh_slot;
    logic             frame_last;
    alarm_e           alarm_q;
    logic             ovh_bit;
    logic             pay_bit;
    logic             par_bit;
    logic             line_bit;
    logic             tx_bit_q;
    logic             tx_oh_q;

    ds3ai_position #(
        .SUBFRAMES  (SUBFRAMES),
        .BLOCKS     (BLOCKS),
        .BLOCK_BITS (BLOCK_BITS)
    ) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .sf_idx     (sf_idx),
        .blk_idx    (blk_idx),
        .oh_slot    (oh_slot),
        .frame_last (frame_last)
    );

    ds3ai_overhead #(
        .SUBFRAMES (SUBFRAMES),
        .BLOCKS    (BLOCKS)
    ) u_ovh (
        .sf_idx   (sf_idx),
        .blk_idx  (blk_idx),
        .alarm    (alarm_q),
        .cbp_mode (cbp_mode),
        .cbit_in  (cbit_in),
        .par_bit  (par_bit),
        .ovh_bit  (ovh_bit)
    );

    ds3ai_filler u_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .oh_slot (oh_slot),
        .alarm   (alarm_q),
        .pay_in  (pay_in),
        .pay_bit (pay_bit)
    );

    ds3ai_parity u_par (
        .clk        (clk),
        .rst_n      (rst_n),
        .oh_slot    (oh_slot),
        .frame_last (frame_last),
        .line_bit   (line_bit),
        .par_bit    (par_bit)
    );

    // Hold the alarm condition for a whole frame; reload on the last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= ALM_NORMAL;
        end else if (frame_last) begin
            alarm_q <= alarm_e'(alarm_sel);
        end
    end

    // Pick overhead or payload for this bit time
    always_comb begin
        line_bit = oh_slot ? ovh_bit : pay_bit;
    end

    // Output register for line bit and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit_q <= 1'b0;
            tx_oh_q  <= 1'b0;
        end else begin
            tx_bit_q <= line_bit;
            tx_oh_q  <= oh_slot;
        end
    end

    assign tx_bit = tx_bit_q;
    assign tx_oh  = tx_oh_q;

endmodule

// File: rtl/ds3ai_checker.sv
`timescale 1ns / 1ps
// Module: ds3ai_checker
// Temporal properties for ds3_alarm_inserter. Attached by bind.
// Assumes rst_n is low before the first clock edge.
module ds3ai_checker
    import ds3ai_pkg::*;
#(
    parameter int SF_W  = 3,
    parameter int BLK_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_bit,
    input logic             tx_oh,
    input logic             oh_slot,
    input logic [SF_W-1:0]  sf_idx,
    input logic [BLK_W-1:0] blk_idx,
    input logic             frame_last,
    input logic [1:0]       alarm_q
);

    // R1: strobe follows overhead slots
    a_r1_strobe_on_oh: assert property (@(posedge clk) disable iff (!rst_n)
        oh_slot |=> tx_oh);
    a_r1_strobe_off_pay: assert property (@(posedge clk) disable iff (!rst_n)
        !oh_slot |=> !tx_oh);

    // R2: F-bit values
    a_r2_f_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (oh_slot && (blk_idx == BLK_W'(1) || blk_idx == BLK_W'(7))) |=> tx_bit);
    a_r2_f_zeros: assert property (@(posedge clk) disable iff (!rst_n)
        (oh_slot && (blk_idx == BLK_W'(3) || blk_idx == BLK_W'(5))) |=> !tx_bit);

    // R4: yellow clears both X bits
    a_r4_yellow_x: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_q == ALM_YELLOW && oh_slot && blk_idx == '0 && sf_idx < SF_W'(2))
        |=> !tx_bit);

    // R5: AIS clears every C-bit
    a_r5_ais_cbits: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_q == ALM_AIS && oh_slot && blk_idx != '0 && !blk_idx[0]) |=> !tx_bit);

    // R5: AIS payload restarts with 1 after overhead
    a_r5_ais_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_q == ALM_AIS && oh_slot) |=> ##1 tx_bit);

    // R6: idle payload restarts with 1 after overhead
    a_r6_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_q == ALM_IDLE && oh_slot) |=> ##1 tx_bit);

    // R10: latched condition moves only after the last bit of a frame
    a_r10_alarm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_last |=> $stable(alarm_q));

    // R11: reset clears the outputs on the next edge
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!tx_bit && !tx_oh));

endmodule

bind ds3_alarm_inserter ds3ai_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_bit     (tx_bit),
    .tx_oh      (tx_oh),
    .oh_slot    (oh_slot),
    .sf_idx     (sf_idx),
    .blk_idx    (blk_idx),
    .frame_last (frame_last),
    .alarm_q    (alarm_q)
);

// File: tb/test_ds3_alarm_inserter.sv
`timescale 1ns / 1ps
// Bench: test_ds3_alarm_inserter
// A table of frame scenarios is walked by one loop. A bit-accurate reference
// built from the requirements checks every output bit. Directed reset and
// alarm-timing cases follow the loop.
module test_ds3_alarm_inserter;

    localparam int SFS        = 7;
    localparam int BLKS       = 8;
    localparam int BBITS      = 85;
    localparam int FRAME_BITS = SFS * BLKS * BBITS;
    localparam int WD_CYCLES  = 190000;
    localparam int MAX_PRINTS = 30;

    typedef struct packed {
        logic [1:0] alm;   // condition for this frame
        logic       mode;  // 1 = C-bit parity
        logic [1:0] kind;  // 0 random, 1 all ones, 2 all zeros
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 1'b0, 2'd0},
        '{2'b01, 1'b1, 2'd0},
        '{2'b11, 1'b0, 2'd1},
        '{2'b11, 1'b1, 2'd0},
        '{2'b10, 1'b0, 2'd0},
        '{2'b10, 1'b1, 2'd0},
        '{2'b10, 1'b1, 2'd1},
        '{2'b00, 1'b1, 2'd2},
        '{2'b01, 1'b0, 2'd1},
        '{2'b00, 1'b0, 2'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pay_in = 1'b0;
    logic       cbit_in = 1'b0;
    logic       cbp_mode = 1'b0;
    logic [1:0] alarm_sel = 2'b00;
    logic       tx_bit;
    logic       tx_oh;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   n_prints = 0;
    bit   finished = 1'b0;

    // reference state
    int       m_sf, m_blk, m_bit;
    logic [1:0] m_act;
    logic     m_par, m_acc;
    logic     have_exp;
    logic     e_bit, e_oh;
    string    e_tag;
    int       kind = 0;
    logic [15:0] lfsr = 16'hACE1;

    ds3_alarm_inserter i_ds3_alarm_inserter (
        .clk       (clk),
        .rst_n     (rst_n),
        .pay_in    (pay_in),
        .cbit_in   (cbit_in),
        .cbp_mode  (cbp_mode),
        .alarm_sel (alarm_sel),
        .tx_bit    (tx_bit),
        .tx_oh     (tx_oh)
    );

    always #10 clk = ~clk;

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            if (n_prints < MAX_PRINTS) begin
                n_prints++;
                $display("FAIL %s: actual %b expected %b at t=%0t", tag, act, exp, $time);
            end
        end
    endtask

    task automatic model_reset();
        m_sf = 0; m_blk = 0; m_bit = 0;
        m_act = 2'b00; m_par = 1'b0; m_acc = 1'b0;
        have_exp = 1'b0;
    endtask

    // One bit time: compare last result, drive new inputs, predict, advance
    task automatic step();
        logic b;
        int   ph;
        if (have_exp) begin
            check(tx_oh, e_oh, "R1 strobe");
            check(tx_bit, e_bit, e_tag);
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        pay_in  = (kind == 0) ? lfsr[0] : (kind == 1);
        cbit_in = lfsr[7];
        e_oh = (m_bit == 0);
        if (m_bit == 0) begin
            case (m_blk)
                1, 7: begin b = 1'b1; e_tag = "R2 F-bit"; end
                3, 5: begin b = 1'b0; e_tag = "R2 F-bit"; end
                0: begin
                    if (m_sf < 2) begin
                        b = (m_act != 2'b01); e_tag = "R4 X-bit";
                    end else if (m_sf < 4) begin
                        b = m_par; e_tag = "R9 P-bit";
                    end else begin
                        b = (m_sf == 5); e_tag = "R3 M-bit";
                    end
                end
                default: begin
                    if (m_act == 2'b11) begin
                        b = 1'b0; e_tag = "R5 AIS C-bit";
                    end else if (m_act == 2'b10) begin
                        b = (cbp_mode && m_sf != 2) ? cbit_in : 1'b0;
                        e_tag = "R7 idle C-bit";
                    end else begin
                        b = cbit_in; e_tag = "R8 C-bit";
                    end
                end
            endcase
        end else begin
            ph = (m_bit - 1) % 4;
            if (m_act == 2'b11) begin
                b = (ph % 2 == 0); e_tag = "R5 AIS payload";
            end else if (m_act == 2'b10) begin
                b = (ph < 2); e_tag = "R6 idle payload";
            end else begin
                b = pay_in; e_tag = "R8 payload";
            end
            m_acc = m_acc ^ b;
        end
        e_bit = b;
        have_exp = 1'b1;
        // advance reference position; R10 latch on last bit
        if (m_bit == BBITS - 1) begin
            m_bit = 0;
            if (m_blk == BLKS - 1) begin
                m_blk = 0;
                if (m_sf == SFS - 1) begin
                    m_sf = 0;
                    m_par = m_acc;
                    m_acc = 1'b0;
                    m_act = alarm_sel;
                end else begin
                    m_sf++;
                end
            end else begin
                m_blk++;
            end
        end else begin
            m_bit++;
        end
        @(negedge clk);
    endtask

    // Reset for three cycles, check cleared outputs, release (R11)
    task automatic do_reset();
        rst_n = 1'b0;
        have_exp = 1'b0;
        repeat (3) @(negedge clk);
        check(tx_bit, 1'b0, "R11 reset tx_bit");
        check(tx_oh, 1'b0, "R11 reset tx_oh");
        model_reset();
        rst_n = 1'b1;
    endtask

    // Run one frame; request next_alm mid-frame after a transient glitch (R10)
    task automatic run_frame(input logic mode, input logic [1:0] kd,
                             input logic [1:0] next_alm);
        cbp_mode = mode;
        kind = kd;
        for (int i = 0; i < FRAME_BITS; i++) begin
            if (i == 500) alarm_sel = ~next_alm;
            if (i == 900) alarm_sel = next_alm;
            step();
        end
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // table walk: frame i carries VECS[i].alm, latched during frame i-1
        for (int i = 0; i < NVEC; i++) begin
            run_frame(VECS[i].mode, VECS[i].kind,
                      (i + 1 < NVEC) ? VECS[i + 1].alm : 2'b11);
        end
        // R11: reset in the middle of an AIS frame
        cbp_mode = 1'b1;
        for (int i = 0; i < 1234; i++) step();
        alarm_sel = 2'b11;
        do_reset();
        // R10/R9: first frame after reset is normal with P=0 even though AIS is requested
        kind = 0;
        for (int i = 0; i < FRAME_BITS; i++) step();
        // then AIS in C-bit parity mode, then yellow request for the end
        alarm_sel = 2'b01;
        for (int i = 0; i < FRAME_BITS + BBITS * 3; i++) step();
        check(tx_oh | ~tx_oh, 1'b1, "R1 final strobe defined");
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule